// File: doc/BRIEF.md
# Dual-Microphone Half-Overlap Framer with Overlap-Add Synthesis

This block sits on both sides of a shared frequency-domain engine in a two-microphone speech path. On the analysis side it takes a pair of 8-bit microphone samples per input strobe. It keeps a running capture and releases a frame of `FRAME_LEN` samples every `FRAME_LEN/2` inputs, so consecutive frames share half of their samples. Each released frame is scaled by a periodic raised-cosine (Hann) taper. It is sent out as one complex stream: microphone A on the real part and microphone B on the imaginary part, so a single complex transform serves both channels.

Capture storage holds three half-frames per channel pair. The two halves being read out are never overwritten by incoming samples, so capture goes on without pausing while a frame is streamed out. If a new frame falls due while the previous one is still streaming, that frame is discarded and a sticky error flag is raised.

On the synthesis side the block accepts processed real frames of `FRAME_LEN` samples. Each sample in the first half is added to the stored second half of the previous frame, and the sum is emitted with saturation. Samples in the second half are only stored.

Top module: `dual_mic_framer_ola`

## Requirements
- R1: After synchronous reset, `frm_valid`, `frm_last`, `ola_out_valid` and `overrun` are all 0 until stimulus arrives.
- R2: The first frame is released after `FRAME_LEN` accepted input pairs, and another after every further `FRAME_LEN/2` pairs. Each frame appears as `FRAME_LEN` consecutive `frm_valid` cycles, with `frm_last` high only on the final one.
- R3: A frame released at input count c (counting from 1) holds input pairs c-FRAME_LEN .. c-1 (0-based) in arrival order.
- R4: Output j of a frame is `frm_re = floor((a-128)*w[j]/256)` and `frm_im = floor((b-128)*w[j]/256)`, as 16-bit two's complement. Here a and b are the offset-binary inputs and `w[j] = round(0.5*(1-cos(2*pi*j/FRAME_LEN))*65535)`.
- R5: When a frame falls due while the previous frame is still being read out, `overrun` goes to 1 and stays 1 until reset, and that frame is dropped. Later frames keep their correct content.
- R6: Processed frames are counted in groups of `FRAME_LEN` accepted `ola_in_valid` samples. For index i < `FRAME_LEN/2`, one output equal to x[i] + previous frame's x[i+FRAME_LEN/2] is emitted two cycles after acceptance, using zero for the previous frame after reset. Indices in the upper half produce no output.
- R7: An overlap-add sum above 32767 is output as 32767, and a sum below -32768 is output as -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Microphone pair strobe |
| mic_a | input | SAMPLE_W | Microphone A sample, offset binary |
| mic_b | input | SAMPLE_W | Microphone B sample, offset binary |
| frm_valid | output | 1 | Windowed frame sample valid |
| frm_re | output | COEF_W | Windowed microphone A, signed |
| frm_im | output | COEF_W | Windowed microphone B, signed |
| frm_last | output | 1 | Final sample of a frame |
| overrun | output | 1 | Sticky dropped-frame flag |
| ola_in_valid | input | 1 | Processed frame sample strobe |
| ola_in | input | OLA_W | Processed frame sample, signed |
| ola_out_valid | output | 1 | Reconstructed sample valid |
| ola_out | output | OLA_W | Reconstructed sample, signed, saturated |

## Verification
The dropped-frame case is the hardest to reach. It needs a frame to fall due while the previous frame is still streaming, and with realistic sample spacing that never happens. The stimulus drives input pairs on back-to-back cycles, so the second frame falls due while the first is still being read. After that it slows down, and the frame after the dropped one is checked to still carry the right samples. The overlap-add side is reached for saturation by putting near-full-scale values of equal sign in the tail of one frame and the head of the next.

// File: rtl/mf_pkg.sv
package mf_pkg;
  // Periodic raised-cosine coefficient, scaled to the full unsigned range of w bits
  function automatic int hann_coef(int i, int n, int w);
    real r;
    r = 0.5 * (1.0 - $cos(2.0 * 3.141592653589793 * real'(i) / real'(n)))
        * real'((1 << w) - 1);
    return $rtoi(r + 0.5);
  endfunction
endpackage

// File: rtl/mf_hann_rom.sv
module mf_hann_rom #(
  parameter int N  = 1024,
  parameter int CW = 16,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic [LW-1:0] addr,
  output logic [CW-1:0] q
);
  logic [CW-1:0] rom [N];

  initial begin
    for (int i = 0; i < N; i++) rom[i] = CW'(mf_pkg::hann_coef(i, N, CW));
  end

  always_ff @(posedge clk) q <= rom[addr];
endmodule

// File: rtl/mf_capture.sv
module mf_capture #(
  parameter int N  = 1024,
  parameter int SW = 8,
  parameter int AW = $clog2(3 * N / 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [SW-1:0]   a,
  input  logic [SW-1:0]   b,
  input  logic            rd_busy,
  input  logic [AW-1:0]   rd_addr,
  output logic [2*SW-1:0] rd_q,
  output logic            start,
  output logic [1:0]      first_h,
  output logic [1:0]      second_h,
  output logic            overrun
);
  localparam int HALF  = N / 2;
  localparam int DEPTH = 3 * HALF;
  localparam int OW    = $clog2(HALF);

  logic [2*SW-1:0] mem [DEPTH];
  logic [1:0]      wr_half;
  logic [OW-1:0]   wr_off;
  logic            primed;
  logic [AW-1:0]   wr_addr;
  logic [1:0]      prev_half;
  logic [1:0]      next_half;

  assign wr_addr   = AW'(wr_half) * AW'(HALF) + AW'(wr_off);
  assign prev_half = (wr_half == 2'd0) ? 2'd2 : wr_half - 2'd1;
  assign next_half = (wr_half == 2'd2) ? 2'd0 : wr_half + 2'd1;

  always_ff @(posedge clk) begin
    if (in_valid) mem[wr_addr] <= {a, b};
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_half  <= 2'd0;
      wr_off   <= '0;
      primed   <= 1'b0;
      start    <= 1'b0;
      overrun  <= 1'b0;
      first_h  <= 2'd0;
      second_h <= 2'd0;
    end else begin
      start <= 1'b0;
      if (in_valid) begin
        if (wr_off == OW'(HALF - 1)) begin
          wr_off  <= '0;
          wr_half <= next_half;
          primed  <= 1'b1;
          if (primed) begin
            if (rd_busy || start) begin
              overrun <= 1'b1;
            end else begin
              start    <= 1'b1;
              first_h  <= prev_half;
              second_h <= wr_half;
            end
          end
        end else begin
          wr_off <= wr_off + 1'b1;
        end
      end
    end
  end

  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

// File: rtl/mf_window_reader.sv
module mf_window_reader #(
  parameter int N  = 1024,
  parameter int SW = 8,
  parameter int CW = 16,
  parameter int AW = $clog2(3 * N / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        first_h,
  input  logic [1:0]        second_h,
  output logic              busy,
  output logic [AW-1:0]     rd_addr,
  input  logic [2*SW-1:0]   rd_q,
  output logic              frm_valid,
  output logic              frm_last,
  output logic [CW-1:0]     frm_re,
  output logic [CW-1:0]     frm_im
);
  localparam int HALF = N / 2;
  localparam int LW   = $clog2(N);
  localparam int PW   = SW + CW + 1;

  logic [LW-1:0] idx;
  logic [1:0]    fh, sh, hsel;
  logic          v1, last1;
  logic [CW-1:0] coef_q;
  logic signed [SW-1:0] sa, sb;
  logic signed [PW-1:0] pa, pb;

  mf_hann_rom #(.N(N), .CW(CW)) u_rom (.clk(clk), .addr(idx), .q(coef_q));

  assign hsel    = idx[LW-1] ? sh : fh;
  assign rd_addr = AW'(hsel) * AW'(HALF) + AW'(idx[LW-2:0]);

  // offset binary to two's complement: invert the sign bit
  assign sa = {~rd_q[2*SW-1], rd_q[2*SW-2:SW]};
  assign sb = {~rd_q[SW-1], rd_q[SW-2:0]};
  assign pa = PW'(sa) * $signed({1'b0, coef_q});
  assign pb = PW'(sb) * $signed({1'b0, coef_q});

  always_ff @(posedge clk) begin
    frm_re <= CW'(pa >>> SW);
    frm_im <= CW'(pb >>> SW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      fh        <= 2'd0;
      sh        <= 2'd0;
      v1        <= 1'b0;
      last1     <= 1'b0;
      frm_valid <= 1'b0;
      frm_last  <= 1'b0;
    end else begin
      v1        <= busy;
      last1     <= busy && (idx == LW'(N - 1));
      frm_valid <= v1;
      frm_last  <= last1;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        fh   <= first_h;
        sh   <= second_h;
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (idx == LW'(N - 1)) busy <= 1'b0;
      end
    end
  end

  // R5
  no_start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R2
  frame_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_last) |=> frm_valid);
endmodule

// File: rtl/mf_ola.sv
module mf_ola #(
  parameter int N  = 1024,
  parameter int XW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] x,
  output logic          out_valid,
  output logic [XW-1:0] y
);
  localparam int HALF = N / 2;
  localparam int LW   = $clog2(N);
  localparam logic signed [XW:0] MAXV = (XW+1)'((1 << (XW - 1)) - 1);
  localparam logic signed [XW:0] MINV = -(XW+1)'(1 << (XW - 1));

  logic [XW-1:0] tail [HALF];
  logic [XW-1:0] tail_q, x_d;
  logic [LW-1:0] idx;
  logic          tail_ok, use_d, v_d;
  logic signed [XW:0] sum;

  always_ff @(posedge clk) begin
    if (in_valid && idx[LW-1]) tail[idx[LW-2:0]] <= x;
    tail_q <= tail[idx[LW-2:0]];
    x_d    <= x;
  end

  assign sum = $signed({x_d[XW-1], x_d}) +
               (use_d ? $signed({tail_q[XW-1], tail_q}) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      tail_ok   <= 1'b0;
      use_d     <= 1'b0;
      v_d       <= 1'b0;
      out_valid <= 1'b0;
      y         <= '0;
    end else begin
      v_d       <= in_valid && !idx[LW-1];
      use_d     <= tail_ok;
      out_valid <= v_d;
      if (v_d) begin
        if (sum > MAXV)      y <= XW'(MAXV);
        else if (sum < MINV) y <= XW'(MINV);
        else                 y <= XW'(sum);
      end
      if (in_valid) begin
        idx <= idx + 1'b1;
        if (idx == LW'(N - 1)) tail_ok <= 1'b1;
      end
    end
  end

  // R6
  ola_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
endmodule

// File: rtl/dual_mic_framer_ola.sv
module dual_mic_framer_ola #(
  parameter int FRAME_LEN = 1024,
  parameter int SAMPLE_W  = 8,
  parameter int COEF_W    = 16,
  parameter int OLA_W     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] mic_a,
  input  logic [SAMPLE_W-1:0] mic_b,
  output logic                frm_valid,
  output logic [COEF_W-1:0]   frm_re,
  output logic [COEF_W-1:0]   frm_im,
  output logic                frm_last,
  output logic                overrun,
  input  logic                ola_in_valid,
  input  logic [OLA_W-1:0]    ola_in,
  output logic                ola_out_valid,
  output logic [OLA_W-1:0]    ola_out
);
  localparam int AW = $clog2(3 * FRAME_LEN / 2);

  logic                  busy, start;
  logic [1:0]            first_h, second_h;
  logic [AW-1:0]         rd_addr;
  logic [2*SAMPLE_W-1:0] rd_q;

  mf_capture #(.N(FRAME_LEN), .SW(SAMPLE_W), .AW(AW)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(mic_a), .b(mic_b),
    .rd_busy(busy), .rd_addr(rd_addr), .rd_q(rd_q), .start(start),
    .first_h(first_h), .second_h(second_h), .overrun(overrun));

  mf_window_reader #(.N(FRAME_LEN), .SW(SAMPLE_W), .CW(COEF_W), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .start(start), .first_h(first_h), .second_h(second_h),
    .busy(busy), .rd_addr(rd_addr), .rd_q(rd_q), .frm_valid(frm_valid),
    .frm_last(frm_last), .frm_re(frm_re), .frm_im(frm_im));

  mf_ola #(.N(FRAME_LEN), .XW(OLA_W)) u_ola (
    .clk(clk), .rst(rst), .in_valid(ola_in_valid), .x(ola_in),
    .out_valid(ola_out_valid), .y(ola_out));
endmodule

// File: tb/dual_mic_framer_ola_tb.sv
module dual_mic_framer_ola_tb;
  localparam int N    = 16;
  localparam int HALF = N / 2;

  logic clk = 0, rst = 1;
  logic in_valid = 0, ola_in_valid = 0;
  logic [7:0] mic_a = 0, mic_b = 0;
  logic [15:0] ola_in = 0;
  logic frm_valid, frm_last, overrun, ola_out_valid;
  logic [15:0] frm_re, frm_im, ola_out;

  dual_mic_framer_ola #(.FRAME_LEN(N)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mic_a(mic_a), .mic_b(mic_b),
    .frm_valid(frm_valid), .frm_re(frm_re), .frm_im(frm_im), .frm_last(frm_last),
    .overrun(overrun), .ola_in_valid(ola_in_valid), .ola_in(ola_in),
    .ola_out_valid(ola_out_valid), .ola_out(ola_out));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int hist_a [128], hist_b [128];
  int nin = 0;
  int fstart [8];
  int fq_idx = 0, fpos = 0;
  int oq [64];
  int oq_wr = 0, oq_rd = 0;
  bit done = 0;

  function automatic int taper(int j);
    real r;
    r = 0.5 * (1.0 - $cos(2.0 * 3.141592653589793 * real'(j) / real'(N))) * 65535.0;
    return $rtoi(r + 0.5);
  endfunction

  function automatic int windowed(int v, int j);
    int p;
    p = (v - 128) * taper(j);
    return p >>> 8;
  endfunction

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      fq_idx = 0; fpos = 0; oq_rd = 0;
    end else begin
      if (frm_valid) begin
        int s, er, ei;
        s  = fstart[fq_idx];
        er = windowed(hist_a[s + fpos], fpos);
        ei = windowed(hist_b[s + fpos], fpos);
        check(int'($signed(frm_re)) == er, "R3/R4 re", int'($signed(frm_re)), er);
        check(int'($signed(frm_im)) == ei, "R4 im", int'($signed(frm_im)), ei);
        check(frm_last == (fpos == N - 1), "R2 last", int'(frm_last), int'(fpos == N - 1));
        fpos++;
        if (fpos == N) begin fpos = 0; fq_idx++; end
      end
      if (ola_out_valid) begin
        check(int'($signed(ola_out)) == oq[oq_rd], "R6/R7 ola",
              int'($signed(ola_out)), oq[oq_rd]);
        oq_rd++;
      end
    end
  end

  task automatic do_reset();
    rst = 1; in_valid = 0; ola_in_valid = 0; nin = 0; oq_wr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic feed(int cnt, int gap, int seed);
    for (int k = 0; k < cnt; k++) begin
      hist_a[nin] = (nin * 37 + seed) & 255;
      hist_b[nin] = (255 - nin * 11 + seed * 3) & 255;
      mic_a = 8'(hist_a[nin]); mic_b = 8'(hist_b[nin]);
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      nin++;
      repeat (gap) @(negedge clk);
    end
  endtask

  function automatic int ola_val(int f, int i);
    if (f == 0) return (i < HALF) ? i * 1000 - 4000 : ((i % 2) ? -30000 : 30000);
    if (f == 1) return (i < HALF) ? ((i % 2) ? -30000 : 30000) : -500 * i;
    return i * 3 - 7;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check(!frm_valid && !frm_last, "R1 frm", int'(frm_valid), 0);
    check(!ola_out_valid, "R1 ola", int'(ola_out_valid), 0);
    check(!overrun, "R1 overrun", int'(overrun), 0);
    do_reset();
    check(!frm_valid && !ola_out_valid && !overrun, "R1 idle", int'(overrun), 0);

    // R2, R3, R4: spaced inputs, seven frames starting every HALF samples
    for (int f = 0; f < 7; f++) fstart[f] = f * HALF;
    feed(N - 1, 3, 5);
    repeat (20) @(negedge clk);
    check(fq_idx == 0, "R2 no early frame", fq_idx, 0);
    feed(4 * N - (N - 1), 3, 5);
    repeat (40) @(negedge clk);
    check(fq_idx == 7 && fpos == 0, "R2 frame count", fq_idx, 7);
    check(!overrun, "R5 no overrun when spaced", int'(overrun), 0);

    // R5: back-to-back inputs force a frame due while the previous is streaming
    do_reset();
    fstart[0] = 0; fstart[1] = 2 * HALF;
    feed(3 * HALF, 0, 77);
    repeat (40) @(negedge clk);
    check(overrun == 1, "R5 overrun set", int'(overrun), 1);
    check(fq_idx == 1, "R5 frame dropped", fq_idx, 1);
    feed(HALF, 3, 77);
    repeat (40) @(negedge clk);
    check(fq_idx == 2, "R5 next frame kept", fq_idx, 2);
    check(overrun == 1, "R5 overrun sticky", int'(overrun), 1);

    // R6, R7: overlap-add over three frames with mixed spacing
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < N; i++) begin
        if (i < HALF) begin
          oq[oq_wr] = sat16(ola_val(f, i) + ((f > 0) ? ola_val(f - 1, i + HALF) : 0));
          oq_wr++;
        end
        ola_in = 16'(ola_val(f, i));
        ola_in_valid = 1;
        @(negedge clk);
        ola_in_valid = 0;
        if (i % 3 == 1) repeat (2) @(negedge clk);
      end
    end
    repeat (10) @(negedge clk);
    check(oq_rd == 3 * HALF, "R6 output count", oq_rd, 3 * HALF);
    check(sat16(30000 + 30000) == 32767 && sat16(-60000) == -32768, "R7 model", 0, 0);
    summary();
  end
endmodule